// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The block collects up to 32 external interrupt request lines, conditions each one according to a programmable trigger mode, and picks a single winner for the CPU. Every source carries a 3-bit priority level, where zero masks it, and a 2-bit trigger mode that selects active-low level, active-high level, falling edge or rising edge. Edge-mode sources are captured in sticky latches. Software clears a latch by writing that source's number to a status-control word.

Arbitration is combinational. A source is eligible when it is active and its level is above a programmable threshold. Among the eligible sources the highest level wins, and a tie goes to the lowest source number. The result appears in a current-status word that holds a pending flag, the winning level and the winning source number. A single interrupt line to the CPU is asserted when a source is pending and the global enable is set. Software reaches every register through a plain 32-bit register port with an address, a write strobe, write data and combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all registers read zero, no source is pending and `irq_o` is low.
- R2: Byte addresses decode as follows: 0x00 holds the global enable in bit 0, 0x40 holds the threshold in bits 2:0, and 0x04 and 0x08 are the mode words. Every stored field reads back as written. Unused bits, the write-only word 0x60 and any unmapped word read zero.
- R3: Source n owns a byte in the level word at address 0x10 + 4*((n mod 16)/2), at bit offset (n/16)*16 + (n&1)*8. Only the low 3 bits of that byte are stored, and the upper 5 bits read zero.
- R4: Source n's mode lies in the word at 0x04 (n<16) or 0x08 (n>=16), in bits 2*(n mod 16)+1:2*(n mod 16). The encodings are 00 active-low level, 01 active-high level, 10 falling edge and 11 rising edge. An edge of the opposite direction sets nothing.
- R5: A source takes part in arbitration only when it is active, its level is nonzero and its level is strictly greater than the threshold.
- R6: The highest eligible level wins. Among equal levels the lowest source number wins.
- R7: The current-status word at 0xA0 holds the pending flag in bit 16, the winner's level in bits 10:8 and the winner's number in bits 4:0. It reads zero when nothing is pending.
- R8: An edge latch stays set after the request input returns to idle, until it is cleared. The 32 latches read back at 0x80, with source n in bit n.
- R9: A write to 0x60 with bit 8 set clears the latch of the source numbered in bits 4:0. A write with bit 8 clear leaves every latch unchanged.
- R10: `irq_o` equals the pending flag ANDed with the global enable. The current-status word does not depend on the enable.
- R11: A change on a request input reaches the current-status word after exactly two clock edges for level sources, and after three clock edges for edge latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_req_i | input | 32 | Asynchronous request lines, bit n is source n |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
The hardest situations to create are those where arbitration depends on more than one piece of state at once. One is a level tie resolved by source number while an edge latch from another source is still pending. Another is an active-low source that becomes active only after its mode word is rewritten. The stimulus gets there by building up state in steps. It programs an interleaved level word that serves several sources at once, raises competing requests one after another, and leaves edge latches standing while level sources come and go. Only then does it clear the latches one by one with status-control writes and read back the current-status word after each step. The two-edge input latency is checked by reading in the cycle just before the change is due and again in the cycle it lands.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W = 3;
  localparam int MODE_EDGE_BIT = 1;  // 1: edge, 0: level
  localparam int MODE_POL_BIT  = 0;  // 1: high/rising, 0: low/falling
  // word indices (byte address >> 2)
  localparam logic [5:0] WI_EN       = 6'h00;
  localparam logic [5:0] WI_MODE0    = 6'h01;
  localparam logic [5:0] WI_LVL0     = 6'h04;
  localparam logic [5:0] WI_LVL_LAST = 6'h0B;
  localparam logic [5:0] WI_MASK     = 6'h10;
  localparam logic [5:0] WI_SCLR     = 6'h18;
  localparam logic [5:0] WI_EDGE     = 6'h20;
  localparam logic [5:0] WI_CUR      = 6'h28;
  localparam int SCLR_GO_BIT = 8;
  localparam int CUR_FLAG_BIT = 16;
  localparam int CUR_LVL_LSB  = 8;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [7:0]                  addr_i,
  input  logic                        we_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  input  logic [NSRC-1:0]             edge_i,
  input  logic [31:0]                 cur_i,
  output logic                        en_o,
  output logic [LVL_W-1:0]            thresh_o,
  output logic [NSRC-1:0][1:0]        mode_o,
  output logic [NSRC-1:0][LVL_W-1:0]  prio_o,
  output logic                        clr_o,
  output logic [SRC_W-1:0]            clr_id_o
);
  logic [5:0] widx;
  logic       lvl_hit;
  logic [2:0] lvl_k;

  assign widx    = addr_i[7:2];
  assign lvl_hit = (widx >= WI_LVL0) && (widx <= WI_LVL_LAST);
  assign lvl_k   = 3'(widx - WI_LVL0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      thresh_o <= '0;
      mode_o   <= '0;
      prio_o   <= '0;
    end else if (we_i) begin
      if (widx == WI_EN)   en_o     <= wdata_i[0];
      if (widx == WI_MASK) thresh_o <= wdata_i[LVL_W-1:0];
      for (int n = 0; n < NSRC; n++) begin
        if (widx == WI_MODE0 + 6'(n / 16))
          mode_o[n] <= wdata_i[2*(n%16) +: 2];
        if (lvl_hit && lvl_k == 3'((n % 16) / 2))
          prio_o[n] <= wdata_i[(n/16)*16 + (n%2)*8 +: LVL_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (widx == WI_EN)   rdata_o[0] = en_o;
    if (widx == WI_MASK) rdata_o[LVL_W-1:0] = thresh_o;
    if (widx == WI_EDGE) rdata_o[NSRC-1:0] = edge_i;
    if (widx == WI_CUR)  rdata_o = cur_i;
    for (int n = 0; n < NSRC; n++) begin
      if (widx == WI_MODE0 + 6'(n / 16))
        rdata_o[2*(n%16) +: 2] = mode_o[n];
      if (lvl_hit && lvl_k == 3'((n % 16) / 2))
        rdata_o[(n/16)*16 + (n%2)*8 +: LVL_W] = prio_o[n];
    end
  end

  assign clr_o    = we_i && (widx == WI_SCLR) && wdata_i[SCLR_GO_BIT];
  assign clr_id_o = wdata_i[SRC_W-1:0];
endmodule

// File: rtl/irq_edge.sv
module irq_edge
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0]      req_i,
  input  logic [NSRC-1:0][1:0] mode_i,
  input  logic                 clr_i,
  input  logic [SRC_W-1:0]     clr_id_i,
  output logic [NSRC-1:0]      hit_o,
  output logic [NSRC-1:0]      edge_o,
  output logic [NSRC-1:0]      active_o
);
  logic [NSRC-1:0] s1_q, s2_q, prev_q, clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= req_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic pol;
    assign pol = mode_i[g][MODE_POL_BIT];
    assign hit_o[g] = mode_i[g][MODE_EDGE_BIT] &
                      (pol ? (s2_q[g] & ~prev_q[g]) : (~s2_q[g] & prev_q[g]));
    assign active_o[g] = mode_i[g][MODE_EDGE_BIT] ? edge_o[g]
                                                  : (pol ? s2_q[g] : ~s2_q[g]);
  end

  assign clr_mask = clr_i ? (NSRC'(1) << clr_id_i) : '0;

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_o <= '0;
    else         edge_o <= (edge_o & ~clr_mask) | hit_o;
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            active_i,
  input  logic [NSRC-1:0][LVL_W-1:0] prio_i,
  input  logic [LVL_W-1:0]           thresh_i,
  output logic                       pend_o,
  output logic [LVL_W-1:0]           lvl_o,
  output logic [SRC_W-1:0]           id_o
);
  // downward scan with >= lets the lower index take ties
  always_comb begin
    pend_o = 1'b0;
    lvl_o  = '0;
    id_o   = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (active_i[n] && prio_i[n] > thresh_i && (!pend_o || prio_i[n] >= lvl_o)) begin
        pend_o = 1'b1;
        lvl_o  = prio_i[n];
        id_o   = SRC_W'(n);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      addr_i,
  input  logic            we_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [NSRC-1:0] irq_req_i,
  output logic            irq_o
);
  logic                       en;
  logic [LVL_W-1:0]           thresh;
  logic [NSRC-1:0][1:0]       mode;
  logic [NSRC-1:0][LVL_W-1:0] prio;
  logic                       clr;
  logic [SRC_W-1:0]           clr_id;
  logic [NSRC-1:0]            hit, edge_q, active;
  logic                       pend;
  logic [LVL_W-1:0]           win_lvl;
  logic [SRC_W-1:0]           win_id;
  logic [31:0]                cur;

  irq_regs #(.NSRC(NSRC)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .edge_i(edge_q), .cur_i(cur), .en_o(en), .thresh_o(thresh),
    .mode_o(mode), .prio_o(prio), .clr_o(clr), .clr_id_o(clr_id)
  );

  irq_edge #(.NSRC(NSRC)) u_edge (
    .clk_i, .rst_ni, .req_i(irq_req_i), .mode_i(mode),
    .clr_i(clr), .clr_id_i(clr_id),
    .hit_o(hit), .edge_o(edge_q), .active_o(active)
  );

  irq_arb #(.NSRC(NSRC)) u_arb (
    .active_i(active), .prio_i(prio), .thresh_i(thresh),
    .pend_o(pend), .lvl_o(win_lvl), .id_o(win_id)
  );

  always_comb begin
    cur = '0;
    cur[CUR_FLAG_BIT] = pend;
    cur[CUR_LVL_LSB +: LVL_W] = win_lvl;
    cur[SRC_W-1:0] = win_id;
  end

  assign irq_o = pend & en;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [7:0]                 addr_i,
  input logic                       we_i,
  input logic [31:0]                wdata_i,
  input logic [NSRC-1:0][1:0]       mode,
  input logic [NSRC-1:0][LVL_W-1:0] prio,
  input logic [LVL_W-1:0]           thresh,
  input logic [NSRC-1:0]            active,
  input logic [NSRC-1:0]            hit,
  input logic [NSRC-1:0]            edge_q,
  input logic                       pend,
  input logic [LVL_W-1:0]           win_lvl,
  input logic [SRC_W-1:0]           win_id
);
  // R5
  win_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> (active[win_id] && win_lvl > thresh));

  // R6
  win_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> (prio[win_id] == win_lvl));

  // R9
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[7:2] == WI_SCLR && wdata_i[SCLR_GO_BIT] && !hit[wdata_i[SRC_W-1:0]])
    |=> !edge_q[$past(wdata_i[SRC_W-1:0])]);

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R4
    edge_mode_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(edge_q[g]) |-> $past(mode[g][MODE_EDGE_BIT]));

    // R6
    no_better_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active[g] && prio[g] > thresh) |-> (pend && prio[g] <= win_lvl));
  end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .mode(mode), .prio(prio), .thresh(thresh), .active(active), .hit(hit),
  .edge_q(edge_q), .pend(pend), .win_lvl(win_lvl), .win_id(win_id)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/100ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] req = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  item_t it;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_req_i(req), .irq_o(irq)
  );

  // monitor: each item is compared just after the next rising edge
  initial begin
    forever begin
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      @(posedge clk);
      #1;
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input bit is_irq, input logic [31:0] e, input string tag);
    item_t x;
    x.is_irq = is_irq; x.exp = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; push(1'b0, e, tag);
  endtask

  task automatic rd_now(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a; push(1'b0, e, tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk); push(1'b1, {31'b0, e}, tag);
  endtask

  task automatic set_req(input logic [31:0] v);
    @(negedge clk); req = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state; R5 source 0 active-low with input low but level 0
    rd(8'h00, 32'h0, "R1 enable");
    rd(8'h04, 32'h0, "R1 mode0");
    rd(8'h18, 32'h0, "R1 level word");
    rd(8'h80, 32'h0, "R1 edge status");
    rd(8'hA0, 32'h0, "R1/R5 current status");
    chk_irq(1'b0, "R1 irq");

    // modes: all active-high, src20 rising, src21 falling
    wr(8'h04, 32'h5555_5555);
    wr(8'h08, 32'h5555_5B55);
    rd(8'h08, 32'h5555_5B55, "R2/R4 mode1 readback");
    wr(8'h00, 32'h1);
    // src4=7 (0xFF truncated), src5=3, src20=5, src21=0
    wr(8'h18, 32'h0005_03FF);
    rd(8'h18, 32'h0005_0307, "R3 level word readback");
    rd(8'hA0, 32'h0, "R5 idle inputs");

    // R11 latency: not visible after one edge, visible after two
    set_req(32'h0000_0020);
    rd_now(8'hA0, 32'h0, "R11 one edge");
    rd(8'hA0, 32'h0001_0305, "R11 two edges");
    chk_irq(1'b1, "R10 irq asserted");

    set_req(32'h0000_0030);
    idle(3);
    rd(8'hA0, 32'h0001_0704, "R6 higher level wins");

    wr(8'h40, 32'h7);
    rd(8'hA0, 32'h0, "R5 threshold 7 blocks all");
    chk_irq(1'b0, "R10 no pending");
    wr(8'h40, 32'h3);
    rd(8'h40, 32'h3, "R2 threshold readback");
    rd(8'hA0, 32'h0001_0704, "R5 level 7 above 3");
    wr(8'h40, 32'h6);
    set_req(32'h0000_0020);
    idle(3);
    rd(8'hA0, 32'h0, "R5 level 3 not above 6");
    wr(8'h40, 32'h0);
    rd(8'hA0, 32'h0001_0305, "R5 threshold 0");

    // tie at level 3: src5 and src6
    wr(8'h1C, 32'h0000_0003);
    set_req(32'h0000_0060);
    idle(3);
    rd(8'hA0, 32'h0001_0305, "R6 tie lowest index");
    set_req(32'h0000_0040);
    idle(3);
    rd(8'hA0, 32'h0001_0306, "R6 remaining source");
    set_req(32'h0000_0020);
    idle(3);

    wr(8'h00, 32'h0);
    rd(8'hA0, 32'h0001_0305, "R10 status independent of enable");
    chk_irq(1'b0, "R10 disabled");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h1, "R2 enable bit only");
    chk_irq(1'b1, "R10 re-enabled");
    set_req(32'h0);
    idle(3);
    chk_irq(1'b0, "R10 request gone");

    // rising edge on src20, short pulse
    set_req(32'h0010_0000);
    idle(2);
    set_req(32'h0);
    idle(4);
    rd(8'h80, 32'h0010_0000, "R8 latch held");
    rd(8'hA0, 32'h0001_0514, "R7 edge source status");
    chk_irq(1'b1, "R8 irq from latch");
    wr(8'h60, 32'h0000_0014);
    rd(8'h80, 32'h0010_0000, "R9 no clear without bit 8");
    wr(8'h60, 32'h0000_0114);
    rd(8'h80, 32'h0, "R9 cleared");
    rd(8'hA0, 32'h0, "R9 nothing pending");

    // falling edge on src21, level 2
    wr(8'h18, 32'h0205_0307);
    rd(8'h18, 32'h0205_0307, "R3 byte at offset 24");
    set_req(32'h0020_0000);
    idle(4);
    rd(8'h80, 32'h0, "R4 rise ignored in falling mode");
    set_req(32'h0);
    idle(4);
    rd(8'h80, 32'h0020_0000, "R4 falling edge latched");
    rd(8'hA0, 32'h0001_0215, "R7 src21 level 2");

    // active-low level on src7
    set_req(32'h0000_0080);
    idle(3);
    wr(8'h1C, 32'h0000_0403);
    wr(8'h04, 32'h5555_1555);
    rd(8'h04, 32'h5555_1555, "R2 mode0 readback");
    rd(8'hA0, 32'h0001_0215, "R4 active-low idle when high");
    set_req(32'h0);
    idle(3);
    rd(8'hA0, 32'h0001_0407, "R4 active-low asserted");
    wr(8'h60, 32'h0000_0115);
    rd(8'hA0, 32'h0001_0407, "R9 src21 cleared, src7 remains");
    set_req(32'h0000_0080);
    idle(3);
    rd(8'hA0, 32'h0, "R9 all quiet");

    rd(8'h0C, 32'h0, "R2 gap 0x0C");
    rd(8'h30, 32'h0, "R2 gap 0x30");
    rd(8'h44, 32'h0, "R2 gap 0x44");
    rd(8'h60, 32'h0, "R2 status-control reads zero");

    // highest source number
    wr(8'h2C, 32'h0600_0000);
    rd(8'h2C, 32'h0600_0000, "R3 src31 field");
    set_req(32'h8000_0080);
    idle(3);
    rd(8'hA0, 32'h0001_061F, "R7 source 31");

    wait (q.size() == 0);
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule